// File: doc/BRIEF.md
# Indexed Register Window Controller

This block lets software reach a bank of internal 32-bit registers through a small page of memory-mapped locations. Software first stores an 8-bit index in a select register, then reads or writes a data window; each window access is steered to the internal register that the stored index names. A third location takes end-of-interrupt writes and turns each one into a single-cycle strobe carrying an 8-bit vector.

The block sits on a simple 32-bit memory bus with address, write enable, byte enables, write data and registered read data. It claims one 4 KB page whose upper address bits come from a base input, so the page can be moved at run time. The internal registers are not stored here. A register-file port presents the index, a read enable, a write enable and write data, and takes back read data combinationally. Indices at or above `NUM_REGS` are treated as unimplemented.

Top module: `iwin_ctrl`

## Requirements
- R1: After reset, and after any later reset, the stored index is 0 (visible on `rf_addr_o`), `bus_rvalid_o`, `bus_rdata_o` and `eoi_valid_o` are all low, and a window read returns internal register 0.
- R2: An access is claimed only when `bus_addr_i[31:12]` equals `base_page_i` and `bus_addr_i[11:0]` is 0x000 (select), 0x010 (window) or 0x040 (end of interrupt). Any other address is answered but not acted on: a write has no effect and a read returns zero.
- R3: A full-word write to the select location stores `bus_wdata_i[7:0]` as the index. A read of the select location returns the index in bits 7:0 and zero in bits 31:8, whatever was written to those bits.
- R4: A full-word read of the window location returns the internal register named by the index. `rf_rd_en_o` is raised in the request cycle with `rf_addr_o` equal to the index.
- R5: A full-word write to the window location raises `rf_wr_en_o` for the request cycle, with `rf_addr_o` equal to the index and `rf_wdata_o` equal to `bus_wdata_i`.
- R6: When the index is `NUM_REGS` or above, a window read returns zero whatever `rf_rdata_i` holds, and a window write raises no `rf_wr_en_o`.
- R7: Any access whose byte enables are not all ones (0xF) is ignored as a write at every location and returns zero as a read.
- R8: A full-word write to the end-of-interrupt location raises `eoi_valid_o` for exactly the next cycle, with `eoi_vector_o` equal to the written bits 7:0. A read of that location returns zero.
- R9: A change of `base_page_i` moves the claimed page at once: the old page is no longer decoded, and the new page is.
- R10: `bus_rvalid_o` is high exactly in the cycle after a read request, and `bus_rdata_o` is zero whenever `bus_rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_page_i | input | 20 | Page base, compared with address bits 31:12 (software normally sets 0xFEC00) |
| bus_valid_i | input | 1 | Bus request valid for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata_o | output | 32 | Read data, zero when not valid |
| rf_addr_o | output | 8 | Index of the internal register (the stored index) |
| rf_rd_en_o | output | 1 | Internal register read in this cycle |
| rf_wr_en_o | output | 1 | Internal register write in this cycle |
| rf_wdata_o | output | 32 | Data for the internal register write |
| rf_rdata_i | input | 32 | Data of the internal register at `rf_addr_o` |
| eoi_valid_o | output | 1 | End-of-interrupt strobe |
| eoi_vector_o | output | 8 | Vector carried with the strobe |

## Verification
A wrong stored index shows up on `rf_addr_o` in the cycle after the faulty select write. It also shows in the next window read, which returns data from the wrong register one cycle after the request. A decode or byte-enable fault shows in the request cycle itself as a stray or missing `rf_wr_en_o`, or one cycle later as non-zero data from an ignored location. The bench places window accesses on both sides of the `NUM_REGS` boundary, uses a register-file model that returns a poison word for unimplemented indices, and moves the page so that a decode tied to a fixed base is exposed.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

  // Locations inside the claimed page; the offsets are part of the block's contract.
  localparam int unsigned OFS_SELECT = 32'h000;
  localparam int unsigned OFS_WINDOW = 32'h010;
  localparam int unsigned OFS_EOI    = 32'h040;

  // Which visible location a request lands on.
  typedef enum logic [1:0] {
    SLOT_NONE,
    SLOT_SELECT,
    SLOT_WINDOW,
    SLOT_EOI
  } slot_e;

endpackage

// File: rtl/iwin_rst_sync.sv
module iwin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/iwin_decode.sv
module iwin_decode
  import iwin_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned BE_W     = 4
) (
  input  logic                       req_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [BE_W-1:0]            be_i,
  input  logic [ADDR_W-PAGE_LSB-1:0] base_page_i,
  output slot_e                      slot_o,
  output logic                       full_word_o
);

  localparam logic [PAGE_LSB-1:0] SEL_OFS = PAGE_LSB'(OFS_SELECT);
  localparam logic [PAGE_LSB-1:0] WIN_OFS = PAGE_LSB'(OFS_WINDOW);
  localparam logic [PAGE_LSB-1:0] EOI_OFS = PAGE_LSB'(OFS_EOI);

  logic                in_page;
  logic [PAGE_LSB-1:0] offset;

  assign in_page     = (addr_i[ADDR_W-1:PAGE_LSB] == base_page_i);
  assign offset      = addr_i[PAGE_LSB-1:0];
  assign full_word_o = &be_i;

  always_comb begin
    slot_o = SLOT_NONE;
    if (req_i && in_page) begin
      unique case (offset)
        SEL_OFS: slot_o = SLOT_SELECT;
        WIN_OFS: slot_o = SLOT_WINDOW;
        EOI_OFS: slot_o = SLOT_EOI;
        default: slot_o = SLOT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/iwin_select.sv
module iwin_select #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = load_i;
    idx_d  = load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/iwin_port.sv
module iwin_port #(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 16
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              win_rd_i,
  input  logic              win_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic [IDX_W-1:0]  rf_addr_o,
  output logic              rf_rd_en_o,
  output logic              rf_wr_en_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic [DATA_W-1:0] win_rdata_o
);

  logic implemented;

  assign implemented = (32'(idx_i) < NUM_REGS);

  always_comb begin
    rf_addr_o   = idx_i;
    rf_wdata_o  = wdata_i;
    rf_rd_en_o  = win_rd_i && implemented;
    rf_wr_en_o  = win_wr_i && implemented;
    win_rdata_o = implemented ? rf_rdata_i : '0;
  end

endmodule

// File: rtl/iwin_eoi.sv
module iwin_eoi #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);

  logic             valid_q, valid_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_en;

  always_comb begin
    valid_d = fire_i;
    vec_en  = fire_i;
    vec_d   = vec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
    end else if (vec_en) begin
      vec_q <= vec_d;
    end
  end

  assign valid_o = valid_q;
  assign vec_o   = vec_q;

endmodule

// File: rtl/iwin_ctrl.sv
module iwin_ctrl
  import iwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAGE_LSB  = 12,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-PAGE_LSB-1:0] base_page_i,
  input  logic                       bus_valid_i,
  input  logic                       bus_we_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W/8-1:0]        bus_be_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic                       bus_rvalid_o,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic [IDX_W-1:0]           rf_addr_o,
  output logic                       rf_rd_en_o,
  output logic                       rf_wr_en_o,
  output logic [DATA_W-1:0]          rf_wdata_o,
  input  logic [DATA_W-1:0]          rf_rdata_i,
  output logic                       eoi_valid_o,
  output logic [VEC_W-1:0]           eoi_vector_o
);

  localparam int unsigned BE_W = DATA_W / 8;

  logic              rst_n_sync;
  slot_e             slot;
  logic              full_word;
  logic              acc_rd, acc_wr;
  logic              sel_load, win_rd, win_wr, eoi_fire;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] win_rdata;

  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  iwin_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  iwin_decode #(
    .ADDR_W   (ADDR_W),
    .PAGE_LSB (PAGE_LSB),
    .BE_W     (BE_W)
  ) u_dec (
    .req_i       (bus_valid_i),
    .addr_i      (bus_addr_i),
    .be_i        (bus_be_i),
    .base_page_i (base_page_i),
    .slot_o      (slot),
    .full_word_o (full_word)
  );

  // Request qualification: partial-width writes are dropped here.
  always_comb begin
    acc_wr   = bus_valid_i && bus_we_i && full_word;
    acc_rd   = bus_valid_i && !bus_we_i;
    sel_load = acc_wr && (slot == SLOT_SELECT);
    win_wr   = acc_wr && (slot == SLOT_WINDOW);
    win_rd   = acc_rd && full_word && (slot == SLOT_WINDOW);
    eoi_fire = acc_wr && (slot == SLOT_EOI);
  end

  iwin_select #(.IDX_W(IDX_W)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .load_i     (sel_load),
    .load_val_i (bus_wdata_i[IDX_W-1:0]),
    .idx_o      (idx)
  );

  iwin_port #(
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_port (
    .idx_i       (idx),
    .win_rd_i    (win_rd),
    .win_wr_i    (win_wr),
    .wdata_i     (bus_wdata_i),
    .rf_rdata_i  (rf_rdata_i),
    .rf_addr_o   (rf_addr_o),
    .rf_rd_en_o  (rf_rd_en_o),
    .rf_wr_en_o  (rf_wr_en_o),
    .rf_wdata_o  (rf_wdata_o),
    .win_rdata_o (win_rdata)
  );

  iwin_eoi #(.VEC_W(VEC_W)) u_eoi (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .fire_i  (eoi_fire),
    .vec_i   (bus_wdata_i[VEC_W-1:0]),
    .valid_o (eoi_valid_o),
    .vec_o   (eoi_vector_o)
  );

  // Read return path: one register stage, zero whenever nothing is returned.
  always_comb begin
    rvalid_d = acc_rd;
    rdata_en = acc_rd || rvalid_q;
    rdata_d  = '0;
    if (acc_rd && full_word) begin
      unique case (slot)
        SLOT_SELECT: rdata_d = DATA_W'(idx);
        SLOT_WINDOW: rdata_d = win_rdata;
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rvalid_o = rvalid_q;
  assign bus_rdata_o  = rdata_q;

endmodule

// File: rtl/iwin_ctrl_chk.sv
module iwin_ctrl_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned VEC_W    = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-PAGE_LSB-1:0] base_page_i,
  input logic                       bus_valid_i,
  input logic                       bus_we_i,
  input logic [ADDR_W-1:0]          bus_addr_i,
  input logic [DATA_W/8-1:0]        bus_be_i,
  input logic [DATA_W-1:0]          bus_wdata_i,
  input logic                       bus_rvalid_o,
  input logic [DATA_W-1:0]          bus_rdata_o,
  input logic [IDX_W-1:0]           rf_addr_o,
  input logic                       rf_rd_en_o,
  input logic                       rf_wr_en_o,
  input logic [VEC_W-1:0]           eoi_vector_o,
  input logic                       eoi_valid_o
);

  logic hit_page;
  logic full_wr;
  assign hit_page = (bus_addr_i[ADDR_W-1:PAGE_LSB] == base_page_i);
  assign full_wr  = bus_valid_i && bus_we_i && (&bus_be_i) && hit_page;

  AST_RF_WR_FULL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_en_o |-> (bus_valid_i && bus_we_i && (&bus_be_i))); // R7

  AST_RF_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_en_o |-> (32'(rf_addr_o) < NUM_REGS)); // R6

  AST_RF_WR_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_en_o |-> (hit_page && (32'(bus_addr_i[PAGE_LSB-1:0]) == 32'h010))); // R2

  AST_RF_RD_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_rd_en_o |-> (bus_valid_i && !bus_we_i && !rf_wr_en_o)); // R4

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> $past(bus_valid_i && !bus_we_i)); // R10

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rvalid_o |-> (bus_rdata_o == '0)); // R10

  AST_EOI_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid_o |-> ($past(full_wr && (32'(bus_addr_i[PAGE_LSB-1:0]) == 32'h040))
                     && (eoi_vector_o == $past(bus_wdata_i[VEC_W-1:0])))); // R8

  AST_SEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(full_wr && (32'(bus_addr_i[PAGE_LSB-1:0]) == 32'h000)) |-> $stable(rf_addr_o)); // R3

endmodule

bind iwin_ctrl iwin_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PAGE_LSB (PAGE_LSB),
  .IDX_W    (IDX_W),
  .NUM_REGS (NUM_REGS),
  .VEC_W    (VEC_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .base_page_i  (base_page_i),
  .bus_valid_i  (bus_valid_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_be_i     (bus_be_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rvalid_o (bus_rvalid_o),
  .bus_rdata_o  (bus_rdata_o),
  .rf_addr_o    (rf_addr_o),
  .rf_rd_en_o   (rf_rd_en_o),
  .rf_wr_en_o   (rf_wr_en_o),
  .eoi_vector_o (eoi_vector_o),
  .eoi_valid_o  (eoi_valid_o)
);

// File: tb/iwin_ctrl_tb_top.sv
module iwin_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 16;
  localparam logic [19:0] PAGE_A = 20'hFEC00;
  localparam logic [19:0] PAGE_B = 20'h12345;

  logic        clk;
  logic        rst_n;
  logic [19:0] base_page;
  logic        bus_valid, bus_we;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [7:0]  rf_addr;
  logic        rf_rd_en, rf_wr_en;
  logic [31:0] rf_wdata, rf_rdata;
  logic        eoi_valid;
  logic [7:0]  eoi_vector;

  int checks   = 0;
  int failures = 0;

  iwin_ctrl #(.NUM_REGS(NREG)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .base_page_i  (base_page),
    .bus_valid_i  (bus_valid),
    .bus_we_i     (bus_we),
    .bus_addr_i   (bus_addr),
    .bus_be_i     (bus_be),
    .bus_wdata_i  (bus_wdata),
    .bus_rvalid_o (bus_rvalid),
    .bus_rdata_o  (bus_rdata),
    .rf_addr_o    (rf_addr),
    .rf_rd_en_o   (rf_rd_en),
    .rf_wr_en_o   (rf_wr_en),
    .rf_wdata_o   (rf_wdata),
    .rf_rdata_i   (rf_rdata),
    .eoi_valid_o  (eoi_valid),
    .eoi_vector_o (eoi_vector)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Register-file model; unimplemented indices return a poison word.
  logic [31:0] model [NREG];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) model[i] <= '0;
    end else if (rf_wr_en) begin
      model[rf_addr[3:0]] <= rf_wdata;
    end
  end
  assign rf_rdata = (32'(rf_addr) < NREG) ? model[rf_addr[3:0]] : 32'hDEAD_BEEF;

  typedef struct packed {
    logic        we;
    logic [11:0] off;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_wr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 4'hF, 32'h0000_0103, 32'h0, 1'b0, 4'd3},  // R3 stores 03
    '{1'b0, 12'h000, 4'hF, 32'h0,         32'h0000_0003, 1'b0, 4'd3},  // R3 upper bits zero
    '{1'b1, 12'h010, 4'hF, 32'hA5A5_0001, 32'h0, 1'b1, 4'd5},  // R5
    '{1'b0, 12'h010, 4'hF, 32'h0,         32'hA5A5_0001, 1'b0, 4'd4},  // R4
    '{1'b1, 12'h000, 4'hF, 32'h0000_0005, 32'h0, 1'b0, 4'd3},
    '{1'b1, 12'h010, 4'hF, 32'h1234_5678, 32'h0, 1'b1, 4'd5},
    '{1'b0, 12'h010, 4'hF, 32'h0,         32'h1234_5678, 1'b0, 4'd4},
    '{1'b1, 12'h000, 4'hF, 32'h0000_0003, 32'h0, 1'b0, 4'd3},
    '{1'b0, 12'h010, 4'hF, 32'h0,         32'hA5A5_0001, 1'b0, 4'd4},  // R4 other index
    '{1'b1, 12'h010, 4'h3, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd7},  // R7 partial write
    '{1'b0, 12'h010, 4'hF, 32'h0,         32'hA5A5_0001, 1'b0, 4'd7},
    '{1'b0, 12'h010, 4'h1, 32'h0,         32'h0, 1'b0, 4'd7},  // R7 partial read
    '{1'b1, 12'h000, 4'h1, 32'h0000_0009, 32'h0, 1'b0, 4'd7},
    '{1'b0, 12'h000, 4'hF, 32'h0,         32'h0000_0003, 1'b0, 4'd7},
    '{1'b1, 12'h020, 4'hF, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd2},  // R2 hole
    '{1'b0, 12'h020, 4'hF, 32'h0,         32'h0, 1'b0, 4'd2},
    '{1'b1, 12'h000, 4'hF, 32'h0000_000F, 32'h0, 1'b0, 4'd6},  // R6 last implemented
    '{1'b1, 12'h010, 4'hF, 32'hCAFE_000F, 32'h0, 1'b1, 4'd6},
    '{1'b0, 12'h010, 4'hF, 32'h0,         32'hCAFE_000F, 1'b0, 4'd6},
    '{1'b1, 12'h000, 4'hF, 32'h0000_0010, 32'h0, 1'b0, 4'd6},  // R6 first unimplemented
    '{1'b0, 12'h010, 4'hF, 32'h0,         32'h0, 1'b0, 4'd6},
    '{1'b1, 12'h010, 4'hF, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd6},
    '{1'b1, 12'h000, 4'hF, 32'h0000_00FF, 32'h0, 1'b0, 4'd6},
    '{1'b0, 12'h010, 4'hF, 32'h0,         32'h0, 1'b0, 4'd6},
    '{1'b0, 12'h000, 4'hF, 32'h0,         32'h0000_00FF, 1'b0, 4'd3},
    '{1'b0, 12'h040, 4'hF, 32'h0,         32'h0, 1'b0, 4'd8},  // R8 read is zero
    '{1'b1, 12'h000, 4'hF, 32'h0000_0000, 32'h0, 1'b0, 4'd3},
    '{1'b0, 12'h010, 4'hF, 32'h0,         32'h0, 1'b0, 4'd6},  // reg0 untouched
    '{1'b0, 12'h004, 4'hF, 32'h0,         32'h0, 1'b0, 4'd2}   // R2 near miss
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge, sample the write strobe before the
  // rising edge, sample the read return at the following falling edge.
  task automatic access(input logic we, input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, output logic wr_seen,
                        output logic rv, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = addr; bus_be = be; bus_wdata = wd;
    #1 wr_seen = rf_wr_en;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
    rv = bus_rvalid;
    rd = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  bit done = 0;

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic wr_seen, rv;
    logic [31:0] rd;
    bus_valid = 0; bus_we = 0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    base_page = PAGE_A;
    do_reset();

    // R1 reset state
    check("R1", "rf_addr", 32'(rf_addr), 32'h0);
    check("R1", "rvalid", 32'(bus_rvalid), 32'h0);
    check("R1", "rdata", bus_rdata, 32'h0);
    check("R1", "eoi_valid", 32'(eoi_valid), 32'h0);
    access(1'b0, {PAGE_A, 12'h010}, 4'hF, 32'h0, wr_seen, rv, rd);
    check("R1", "window reads reg0", rd, 32'h0);
    check("R10", "rvalid after read", 32'(rv), 32'h1);

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].we, {PAGE_A, VECS[v].off}, VECS[v].be, VECS[v].wd, wr_seen, rv, rd);
      check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d rf_wr_en", v), 32'(wr_seen), 32'(VECS[v].exp_wr));
      if (!VECS[v].we) begin
        check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d rdata", v), rd, VECS[v].exp_rd);
        check("R10", $sformatf("vec %0d rvalid", v), 32'(rv), 32'h1);
      end else begin
        check("R10", $sformatf("vec %0d rvalid on write", v), 32'(rv), 32'h0);
      end
    end

    // R10 idle: no read pending, data zero
    @(negedge clk);
    check("R10", "idle rvalid", 32'(bus_rvalid), 32'h0);
    check("R10", "idle rdata", bus_rdata, 32'h0);

    // R8 end-of-interrupt strobe
    access(1'b1, {PAGE_A, 12'h040}, 4'hF, 32'h0000_01A7, wr_seen, rv, rd);
    check("R8", "eoi_valid pulse", 32'(eoi_valid), 32'h1);
    check("R8", "eoi_vector", 32'(eoi_vector), 32'h0000_00A7);
    @(negedge clk);
    check("R8", "eoi_valid one cycle", 32'(eoi_valid), 32'h0);

    // R7 partial EOI write gives no strobe
    access(1'b1, {PAGE_A, 12'h040}, 4'h7, 32'h0000_0055, wr_seen, rv, rd);
    check("R7", "partial eoi no strobe", 32'(eoi_valid), 32'h0);

    // R9 relocation
    base_page = PAGE_B;
    access(1'b1, {PAGE_A, 12'h000}, 4'hF, 32'h0000_0007, wr_seen, rv, rd);
    check("R9", "old page write ignored", 32'(rf_addr), 32'h0);
    access(1'b0, {PAGE_A, 12'h000}, 4'hF, 32'h0, wr_seen, rv, rd);
    check("R9", "old page reads zero", rd, 32'h0);
    access(1'b1, {PAGE_B, 12'h000}, 4'hF, 32'h0000_0003, wr_seen, rv, rd);
    access(1'b0, {PAGE_B, 12'h010}, 4'hF, 32'h0, wr_seen, rv, rd);
    check("R9", "new page window", rd, 32'hA5A5_0001);
    access(1'b0, {PAGE_B, 12'h000}, 4'hF, 32'h0, wr_seen, rv, rd);
    check("R9", "new page select", rd, 32'h0000_0003);

    // R1 second reset clears index
    do_reset();
    check("R1", "index after reset", 32'(rf_addr), 32'h0);
    access(1'b0, {PAGE_B, 12'h000}, 4'hF, 32'h0, wr_seen, rv, rd);
    check("R1", "select reads zero", rd, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule